// File: doc/BRIEF.md
# Epoch-Ordered Persist Buffer

This block sits beside one hardware thread and holds the stores that thread sends toward persistent memory. Each accepted store is written at the tail of a ring together with the thread's current epoch number. The buffer then sends the stores on to the memory controllers as drain requests. Stores are never merged and never searched for by address, so several versions of one address can sit in the ring at the same time.

Draining works one epoch at a time. Every buffered entry of the oldest epoch goes out as soon as it is present, up to `LANES` requests per cycle, and none of them waits for an acknowledgement. Entries that carry a newer tag stay in the ring until every request of the older epoch has been acknowledged. An epoch retires from the head of the ring only when it has been closed and all of its acknowledgements have come back.

An ordering fence closes the current epoch. A durability fence also closes it, and in addition stalls the thread until everything buffered before it has been acknowledged. Caches are never flushed.

Top module: `epoch_persist_buf`

## Requirements
- R1: After reset, `st_rdy` and `fence_rdy` are 1, `dur_busy` is 0, all `drn_vld` bits are 0 and `cur_epoch` is 0.
- R2: A store is accepted at a clock edge where `st_vld` and `st_rdy` are both 1. It is tagged with the value `cur_epoch` had before that edge, including when a fence is accepted on the same edge.
- R3: A fence is accepted at an edge where `ofence` or `dfence` is 1 and `fence_rdy` is 1. Each accepted fence raises `cur_epoch` by exactly one, modulo 2^`TS_W`, from the next cycle on, whether or not the closing epoch holds any stores.
- R4: Drain requests leave in the order the stores were accepted. Within one cycle, lanes are filled from lane 0 upward with no gap, and lane k carries the (k+1)-th oldest request not yet issued. Each request carries the stored address, data and epoch tag. Repeated stores to one address are each drained separately.
- R5: Every buffered entry of the oldest unretired epoch is issued without waiting for any acknowledgement. Up to `LANES` entries are issued per cycle, starting the cycle after the entry is accepted.
- R6: No request of a newer epoch is issued while any earlier request is still unacknowledged. An acknowledgement is one `drn_ack` bit. It may arrive on any lane and in any order, and the environment never acknowledges more requests than are outstanding. An epoch with no stores needs no acknowledgements.
- R7: When `DEPTH` entries are held, `st_rdy` is 0. A store offered while `st_rdy` is 0 is not taken, and no accepted store is lost.
- R8: After an accepted durability fence, `dur_busy` is 1 from the next cycle. It stays 1 until every store accepted before the fence has been acknowledged. While `dur_busy` is 1, `st_rdy` and `fence_rdy` are 0.
- R9: `fence_rdy` is 0 while 2^`TS_W`-1 epochs are open after the oldest unretired one, so that epoch tags never alias. Otherwise, with `dur_busy` at 0, it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_vld | input | 1 | Store offered |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| st_rdy | output | 1 | Store can be accepted |
| ofence | input | 1 | Ordering fence request |
| dfence | input | 1 | Durability fence request |
| fence_rdy | output | 1 | Fence can be accepted |
| dur_busy | output | 1 | Thread stalled on a durability fence |
| cur_epoch | output | TS_W | Tag of the open epoch |
| drn_vld | output | LANES | Drain request valid, one bit per lane |
| drn_addr | output | LANES*ADDR_W | Request addresses, lane k at bits k*ADDR_W upward |
| drn_data | output | LANES*DATA_W | Request data, lane k at bits k*DATA_W upward |
| drn_epoch | output | LANES*TS_W | Request epoch tags, lane k at bits k*TS_W upward |
| drn_ack | input | LANES | Acknowledgements, each set bit retires one outstanding request |

## Verification
The hardest state to reach from the ports is a later epoch waiting behind an earlier one that has been fully issued but is still unacknowledged. Random stores and random acknowledgements seldom hold the two epochs apart long enough to observe this. The bench therefore switches its acknowledgement driver off, fills one epoch, closes it, and queues a second epoch behind it. It then checks that only the first epoch has left and that the second issues several lanes at once when acknowledgements resume. The same withheld-acknowledgement trick pins the oldest epoch in place, so that enough fences can be issued to drive `fence_rdy` low at the tag-aliasing limit.

// File: rtl/pb_pkg.sv
package pb_pkg;

    typedef enum logic [1:0] {
        FK_NONE    = 2'd0,
        FK_ORDER   = 2'd1,
        FK_DURABLE = 2'd2
    } fence_kind_e;

endpackage

// File: rtl/pb_ring.sv
module pb_ring #(
    parameter int DEPTH = 64,
    parameter int W     = 72,
    parameter int LANES = 2,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                we,
    input  logic [IW-1:0]       waddr,
    input  logic [W-1:0]        wdata,
    input  logic [LANES*IW-1:0] raddr,
    output logic [LANES*W-1:0]  rdata
);

    logic [W-1:0] mem_q [DEPTH];

    // storage has no reset: an entry is only read after it was written
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    for (genvar gk = 0; gk < LANES; gk++) begin : g_rd
        assign rdata[gk*W +: W] = mem_q[raddr[gk*IW +: IW]];
    end

endmodule

// File: rtl/pb_issue_sel.sv
module pb_issue_sel #(
    parameter int LANES = 2,
    parameter int TS_W  = 8,
    parameter int PW    = 7,
    localparam int NW   = $clog2(LANES + 1)
) (
    input  logic [PW-1:0]         avail,
    input  logic [LANES*TS_W-1:0] lane_ts,
    input  logic [TS_W-1:0]       drain_ts,
    output logic [LANES-1:0]      go,
    output logic [NW-1:0]         n_go
);

    logic [LANES-1:0] hit;

    for (genvar gk = 0; gk < LANES; gk++) begin : g_lane
        assign hit[gk] = (PW'(gk) < avail) && (lane_ts[gk*TS_W +: TS_W] == drain_ts);
        if (gk == 0) begin : g_first
            assign go[gk] = hit[gk];
        end else begin : g_next
            assign go[gk] = hit[gk] && go[gk-1];
        end
    end

    always_comb begin
        n_go = '0;
        for (int k = 0; k < LANES; k++) begin
            n_go = n_go + NW'(go[k]);
        end
    end

endmodule

// File: rtl/pb_ack_ctr.sv
module pb_ack_ctr #(
    parameter int LANES = 2,
    parameter int CW    = 7,
    localparam int NW   = $clog2(LANES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NW-1:0]    add,
    input  logic [LANES-1:0] ack,
    output logic [CW-1:0]    outst,
    output logic             zero
);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [NW-1:0] nack;

    always_comb begin
        nack = '0;
        for (int k = 0; k < LANES; k++) begin
            nack = nack + NW'(ack[k]);
        end
        cnt_d = cnt_q + CW'(add) - CW'(nack);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign outst = cnt_q;
    assign zero  = (cnt_q == '0);

    AST_ACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        CW'(nack) <= cnt_q); // R6

endmodule

// File: rtl/epoch_persist_buf.sv
module epoch_persist_buf
    import pb_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int TS_W   = 8,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    st_vld,
    input  logic [ADDR_W-1:0]       st_addr,
    input  logic [DATA_W-1:0]       st_data,
    output logic                    st_rdy,
    input  logic                    ofence,
    input  logic                    dfence,
    output logic                    fence_rdy,
    output logic                    dur_busy,
    output logic [TS_W-1:0]         cur_epoch,
    output logic [LANES-1:0]        drn_vld,
    output logic [LANES*ADDR_W-1:0] drn_addr,
    output logic [LANES*DATA_W-1:0] drn_data,
    output logic [LANES*TS_W-1:0]   drn_epoch,
    input  logic [LANES-1:0]        drn_ack
);

    localparam int IW = $clog2(DEPTH);
    localparam int PW = IW + 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam int NW = $clog2(LANES + 1);
    localparam int EW = TS_W + ADDR_W + DATA_W;
    localparam logic [TS_W-1:0] TS_ONE = TS_W'(1);

    typedef struct packed {
        logic [PW-1:0]   head;
        logic [PW-1:0]   tail;
        logic [PW-1:0]   iss;
        logic [TS_W-1:0] lts;
        logic [TS_W-1:0] dts;
        logic            busy;
    } ctl_t;

    ctl_t c_d, c_q;

    fence_kind_e         fk;
    logic                fence_acc;
    logic                st_fire;
    logic [PW-1:0]       occ;
    logic [PW-1:0]       avail;
    logic                more_here;
    logic                ep_done;
    logic [LANES*IW-1:0] raddr;
    logic [LANES*EW-1:0] rdata;
    logic [LANES*TS_W-1:0] lane_ts;
    logic [LANES-1:0]    go;
    logic [NW-1:0]       n_go;
    logic [CW-1:0]       outst;
    logic                ack_zero;

    // ring storage, one write port, one read port per lane
    pb_ring #(.DEPTH(DEPTH), .W(EW), .LANES(LANES)) u_ring (
        .clk   (clk),
        .we    (st_fire),
        .waddr (c_q.tail[IW-1:0]),
        .wdata ({c_q.lts, st_addr, st_data}),
        .raddr (raddr),
        .rdata (rdata)
    );

    for (genvar gk = 0; gk < LANES; gk++) begin : g_lane
        assign raddr[gk*IW +: IW]         = c_q.iss[IW-1:0] + IW'(gk);
        assign lane_ts[gk*TS_W +: TS_W]   = rdata[gk*EW + ADDR_W + DATA_W +: TS_W];
        assign drn_addr[gk*ADDR_W +: ADDR_W] = rdata[gk*EW + DATA_W +: ADDR_W];
        assign drn_data[gk*DATA_W +: DATA_W] = rdata[gk*EW +: DATA_W];
        assign drn_epoch[gk*TS_W +: TS_W] = lane_ts[gk*TS_W +: TS_W];
    end

    pb_issue_sel #(.LANES(LANES), .TS_W(TS_W), .PW(PW)) u_sel (
        .avail    (avail),
        .lane_ts  (lane_ts),
        .drain_ts (c_q.dts),
        .go       (go),
        .n_go     (n_go)
    );

    pb_ack_ctr #(.LANES(LANES), .CW(CW)) u_ack (
        .clk   (clk),
        .rst_n (rst_n),
        .add   (n_go),
        .ack   (drn_ack),
        .outst (outst),
        .zero  (ack_zero)
    );

    always_comb begin
        occ       = c_q.tail - c_q.head;
        avail     = c_q.tail - c_q.iss;
        st_rdy    = (occ != PW'(DEPTH)) && !c_q.busy;
        fence_rdy = !c_q.busy && ((c_q.lts + TS_ONE) != c_q.dts);
        st_fire   = st_vld && st_rdy;

        if (dfence) begin
            fk = FK_DURABLE;
        end else if (ofence) begin
            fk = FK_ORDER;
        end else begin
            fk = FK_NONE;
        end
        fence_acc = (fk != FK_NONE) && fence_rdy;

        // the oldest epoch is finished once closed, fully issued and fully acked
        more_here = (avail != '0) && (lane_ts[TS_W-1:0] == c_q.dts);
        ep_done   = (c_q.lts != c_q.dts) && !more_here && ack_zero;

        c_d      = c_q;
        c_d.tail = c_q.tail + PW'(st_fire);
        c_d.iss  = c_q.iss + PW'(n_go);
        if (fence_acc) begin
            c_d.lts = c_q.lts + TS_ONE;
        end
        if (ep_done) begin
            c_d.head = c_q.iss;
            c_d.dts  = c_q.dts + TS_ONE;
        end
        if (fence_acc && fk == FK_DURABLE) begin
            c_d.busy = 1'b1;
        end else if (c_q.busy && c_q.head == c_q.tail) begin
            c_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign drn_vld   = go;
    assign cur_epoch = c_q.lts;
    assign dur_busy  = c_q.busy;

    // checker state: epoch of the most recent issue
    logic [TS_W-1:0] chk_last_ep_q;
    logic            chk_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_last_ep_q <= '0;
            chk_seen_q    <= 1'b0;
        end else if (|drn_vld) begin
            chk_last_ep_q <= drn_epoch[TS_W-1:0];
            chk_seen_q    <= 1'b1;
        end
    end

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= PW'(DEPTH)); // R7

    AST_EPOCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_epoch) |-> cur_epoch == $past(cur_epoch) + TS_ONE); // R3

    AST_EPOCH_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (drn_vld[0] && chk_seen_q && drn_epoch[TS_W-1:0] != chk_last_ep_q) |-> ack_zero); // R6

    AST_LANES_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({1'b0, drn_vld} + {{LANES{1'b0}}, 1'b1})); // R4

    AST_DUR_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (dfence && fence_rdy) |=> dur_busy); // R8

    AST_BUSY_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        dur_busy |-> !st_fire); // R8

endmodule

// File: tb/epoch_persist_buf_bench.sv
module epoch_persist_buf_bench;

    localparam int TP = 2;
    localparam int TA = 16;
    localparam int TD = 16;
    localparam int TT = 3;
    localparam int TDEPTH = 16;
    localparam int MAXN = 4096;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic st_vld = 1'b0;
    logic [TA-1:0] st_addr = '0;
    logic [TD-1:0] st_data = '0;
    logic st_rdy;
    logic ofence = 1'b0;
    logic dfence = 1'b0;
    logic fence_rdy;
    logic dur_busy;
    logic [TT-1:0] cur_epoch;
    logic [TP-1:0] drn_vld;
    logic [TP*TA-1:0] drn_addr;
    logic [TP*TD-1:0] drn_data;
    logic [TP*TT-1:0] drn_epoch;
    logic [TP-1:0] drn_ack = '0;

    always #5 clk = ~clk;

    epoch_persist_buf #(.DEPTH(TDEPTH), .ADDR_W(TA), .DATA_W(TD), .TS_W(TT), .LANES(TP)) u_epoch_persist_buf (
        .clk(clk), .rst_n(rst_n), .st_vld(st_vld), .st_addr(st_addr), .st_data(st_data),
        .st_rdy(st_rdy), .ofence(ofence), .dfence(dfence), .fence_rdy(fence_rdy),
        .dur_busy(dur_busy), .cur_epoch(cur_epoch), .drn_vld(drn_vld), .drn_addr(drn_addr),
        .drn_data(drn_data), .drn_epoch(drn_epoch), .drn_ack(drn_ack)
    );

    logic [TA-1:0] m_addr [MAXN];
    logic [TD-1:0] m_data [MAXN];
    logic [TT-1:0] m_ep   [MAXN];
    logic [TT-1:0] m_ts = '0;
    int enq_n = 0, iss_n = 0, ack_n = 0;
    int total = 0, bad = 0, max_lanes = 0;
    bit ack_en = 1'b1;

    task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [TT-1:0] next_ts(input logic [TT-1:0] t);
        return t + TT'(1);
    endfunction

    task automatic monitor();
        int nl = 0;
        chk(cur_epoch == m_ts, "R3", "cur_epoch", cur_epoch, m_ts);
        for (int k = 0; k < TP; k++) begin
            if (drn_vld[k]) begin
                nl++;
                if (k > 0) chk(drn_vld[k-1], "R4", "lane gap", k, 0);
                if (iss_n >= enq_n) begin
                    chk(1'b0, "R4", "spurious request", iss_n, enq_n);
                end else begin
                    chk(drn_addr[k*TA +: TA] == m_addr[iss_n], "R4", "addr", drn_addr[k*TA +: TA], m_addr[iss_n]);
                    chk(drn_data[k*TD +: TD] == m_data[iss_n], "R4", "data", drn_data[k*TD +: TD], m_data[iss_n]);
                    chk(drn_epoch[k*TT +: TT] == m_ep[iss_n], "R2", "epoch tag", drn_epoch[k*TT +: TT], m_ep[iss_n]);
                    if (iss_n > 0 && m_ep[iss_n] != m_ep[iss_n-1])
                        chk(iss_n == ack_n, "R6", "unacked before new epoch", iss_n - ack_n, 0);
                end
                iss_n++;
            end
        end
        if (nl > max_lanes) max_lanes = nl;
    endtask

    task automatic step(input bit sv, input logic [TA-1:0] a, input logic [TD-1:0] d, input bit of, input bit df);
        int pend;
        @(negedge clk);
        pend = iss_n - ack_n;
        monitor();
        for (int k = 0; k < TP; k++) begin
            drn_ack[k] = 1'b0;
            if (ack_en && pend > 0 && ($urandom % 2) == 1) begin
                drn_ack[k] = 1'b1;
                pend--;
                ack_n++;
            end
        end
        st_vld = sv; st_addr = a; st_data = d; ofence = of; dfence = df;
        if (sv && st_rdy) begin
            m_addr[enq_n] = a; m_data[enq_n] = d; m_ep[enq_n] = m_ts;
            enq_n++;
        end
        if ((of || df) && fence_rdy) m_ts = next_ts(m_ts);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, '0, '0, 1'b0, 1'b0);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "WD", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int base, acc, w;
        void'($urandom(32'd20250117));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(st_rdy == 1'b1, "R1", "st_rdy", st_rdy, 1);
        chk(fence_rdy == 1'b1, "R1", "fence_rdy", fence_rdy, 1);
        chk(dur_busy == 1'b0, "R1", "dur_busy", dur_busy, 0);
        chk(drn_vld == '0, "R1", "drn_vld", drn_vld, 0);
        chk(cur_epoch == '0, "R1", "cur_epoch", cur_epoch, 0);

        // R2/R4: same address three times, store and fence on one edge
        step(1'b1, 16'h0010, 16'd1, 1'b0, 1'b0);
        step(1'b1, 16'h0010, 16'd2, 1'b1, 1'b0);
        step(1'b1, 16'h0010, 16'd3, 1'b0, 1'b0);
        step(1'b0, '0, '0, 1'b1, 1'b0);
        idle(20);
        chk(iss_n == 3, "R4", "repeated address versions drained", iss_n, 3);

        // R5/R6: one epoch issues without acks, next epoch held back
        ack_en = 1'b0;
        idle(3);
        base = iss_n;
        max_lanes = 0;
        for (int i = 0; i < 5; i++) step(1'b1, TA'(16'h0100 + i), TD'(i + 50), 1'b0, 1'b0);
        step(1'b0, '0, '0, 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) step(1'b1, TA'(16'h0200 + i), TD'(i + 80), 1'b0, 1'b0);
        step(1'b0, '0, '0, 1'b1, 1'b0);
        idle(10);
        chk(iss_n - base == 5, "R5", "issued without acks", iss_n - base, 5);
        chk(drn_vld == '0, "R6", "newer epoch held", drn_vld, 0);
        ack_en = 1'b1;
        idle(30);
        chk(iss_n == enq_n, "R6", "all drained after acks", iss_n, enq_n);
        chk(max_lanes >= 2, "R5", "lanes in one cycle", max_lanes, 2);

        // R6: empty epochs need no acks
        step(1'b0, '0, '0, 1'b1, 1'b0);
        step(1'b0, '0, '0, 1'b1, 1'b0);
        step(1'b1, 16'h0300, 16'd7, 1'b1, 1'b0);
        idle(20);
        chk(iss_n == enq_n && ack_n == enq_n, "R6", "drain past empty epochs", iss_n, enq_n);

        // R7: fill with acks withheld
        ack_en = 1'b0;
        acc = enq_n;
        for (int i = 0; i < TDEPTH + 3; i++) step(1'b1, TA'(16'h0400 + i), TD'(i), 1'b0, 1'b0);
        step(1'b0, '0, '0, 1'b0, 1'b0);
        chk(enq_n - acc == TDEPTH, "R7", "accepted when filling", enq_n - acc, TDEPTH);
        chk(st_rdy == 1'b0, "R7", "st_rdy when full", st_rdy, 0);
        ack_en = 1'b1;
        step(1'b0, '0, '0, 1'b1, 1'b0);
        idle(40);
        chk(iss_n == enq_n && ack_n == enq_n, "R7", "nothing lost", iss_n, enq_n);

        // R9: tag aliasing guard
        ack_en = 1'b0;
        step(1'b1, 16'h0500, 16'd9, 1'b0, 1'b0);
        for (int i = 0; i < 6; i++) step(1'b0, '0, '0, 1'b1, 1'b0);
        idle(1);
        chk(fence_rdy == 1'b1, "R9", "fence_rdy below limit", fence_rdy, 1);
        step(1'b0, '0, '0, 1'b1, 1'b0);
        idle(1);
        chk(fence_rdy == 1'b0, "R9", "fence_rdy at limit", fence_rdy, 0);
        chk(st_rdy == 1'b1, "R9", "stores still taken", st_rdy, 1);
        ack_en = 1'b1;
        idle(40);
        chk(fence_rdy == 1'b1, "R9", "fence_rdy after drain", fence_rdy, 1);

        // R8: durability fence
        ack_en = 1'b0;
        for (int i = 0; i < 4; i++) step(1'b1, TA'(16'h0600 + i), TD'(i + 3), 1'b0, 1'b0);
        step(1'b0, '0, '0, 1'b0, 1'b1);
        base = enq_n;
        idle(1);
        chk(dur_busy == 1'b1, "R8", "dur_busy after fence", dur_busy, 1);
        chk(st_rdy == 1'b0, "R8", "st_rdy while busy", st_rdy, 0);
        chk(fence_rdy == 1'b0, "R8", "fence_rdy while busy", fence_rdy, 0);
        idle(15);
        chk(dur_busy == 1'b1, "R8", "busy holds without acks", dur_busy, 1);
        ack_en = 1'b1;
        w = 0;
        while (dur_busy && w < 200) begin
            idle(1);
            w++;
        end
        chk(dur_busy == 1'b0, "R8", "busy released", dur_busy, 0);
        chk(ack_n == base, "R8", "all earlier stores acked", ack_n, base);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            ack_en = ($urandom % 4) != 0;
            step(($urandom % 3) != 0, TA'(($urandom % 8) * 4), TD'($urandom),
                 ($urandom % 8) == 0, ($urandom % 96) == 0);
        end
        ack_en = 1'b1;
        idle(5);
        step(1'b0, '0, '0, 1'b1, 1'b0);
        idle(150);
        chk(iss_n == enq_n, "R4", "random: all issued", iss_n, enq_n);
        chk(ack_n == iss_n, "R6", "random: all acked", ack_n, iss_n);
        chk(dur_busy == 1'b0, "R8", "random: idle at end", dur_busy, 0);
        finish_run();
    end

endmodule